// File: doc/BRIEF.md
# Dual-Clock Packet FIFO

This block moves data words from a producer clock domain, where a packet stream arrives, into a consumer clock domain. The consumer clock runs at a nearby but different frequency. The two clocks have no fixed phase relation, and neither runs at a multiple of the other. A small storage array sits between the two domains. A write pointer advances on the producer clock and a read pointer advances on the consumer clock. Each side sees only a synchronized, Gray-coded copy of the other side's pointer.

The producer raises its write enable only while packet data is present. The counter stays frozen otherwise. A write puts the word into the slot the write pointer names, and then the pointer moves on. At rest, that slot is always the next free one. The consumer reads only when its pointer differs from the synchronized copy of the write pointer, and then advances. The slot the writer may be filling is therefore never read. This holds even when the write pointer moves close to a consumer clock edge, because the copy the reader sees can only lag the true pointer. The word read is captured in a register on the consumer edge. Downstream logic gets it for a whole consumer cycle, with a valid strobe.

Top module: `xdom_pkt_fifo`

## Requirements
- R1: While either reset is asserted (active low), and right after both are released, rd_empty is 1, wr_full is 0 and rd_valid is 0. Both pointers start at slot 0.
- R2: A word accepted on a producer edge is stored in the slot the write pointer names, and the pointer then advances by one. Words leave the consumer side in exactly the order they were accepted.
- R3: A write is accepted only when wr_en is 1 and wr_full is 0. After DEPTH accepted writes with no reads, wr_full is 1, and further writes are ignored: none of them ever appears at the output.
- R4: A read is accepted only when rd_en is 1 and rd_empty is 0. A read request while rd_empty is 1 has no effect, so rd_valid stays 0.
- R5: After a read is accepted on a consumer edge, rd_data holds the word and rd_valid is 1 for exactly the following consumer cycle. When no read is accepted, rd_valid is 0 and rd_data keeps its previous value.
- R6: The write pointer crosses to the consumer side as a Gray code, changing at most one bit per producer edge, through two consumer flops. A word written into an empty FIFO does not clear rd_empty on the producer edge that stores it.
- R7: The read pointer crosses to the producer side the same way. Once the FIFO has been drained, wr_full returns to 0 within a few producer cycles.
- R8: With the two clocks at different periods and arbitrary enable patterns on both sides, every accepted word comes out exactly once, in order, with no loss and no duplicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer-domain reset, active low |
| wr_en | input | 1 | Write request, held high only while packet data is present |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | All DEPTH slots are occupied, as seen from the producer side |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer-domain reset, active low |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | rd_data carries a word read on the previous consumer edge |
| rd_data | output | DATA_W | Registered read word |
| rd_empty | output | 1 | No written slot is visible to the consumer |

## Verification
The hardest case to reach from the ports is a reader closing in on the writer while both pointers move in the same interval. In that case the synchronized copy of the write pointer lags the true one by a cycle or two. Every read then lands on the boundary slot. To get there, the bench runs the two clocks at 8 ns and 8.6 ns, so their phase slides through every relation. It also runs a fast consumer that drains the FIFO empty many times against a gappy producer, and a slow consumer that pins the FIFO at full. Each word is checked against an arithmetically generated sequence, so a lost, repeated or early-read slot shows up as a data mismatch.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  localparam int unsigned PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t bin2gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(input ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
module xfifo_wr_ctl #(
  parameter int unsigned AW = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic          wr_full,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray
);
  import xfifo_pkg::*;
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, occ;

  assign rbin_s   = PW'(gray2bin(ptr_t'(rgray_s)));
  assign occ      = wbin - rbin_s;
  assign wr_full  = (occ == PW'(DEPTH));
  assign wr_fire  = wr_en && !wr_full;
  assign wbin_nxt = wbin + PW'(1);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nxt;
      wgray <= PW'(bin2gray(ptr_t'(wbin_nxt)));
    end
  end

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    occ <= PW'(DEPTH));
  assert_gray_step_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
module xfifo_rd_ctl #(
  parameter int unsigned AW = 3
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  output logic          rd_empty,
  output logic          rd_fire,
  output logic          rd_valid,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray
);
  import xfifo_pkg::*;
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, avail;

  assign wbin_s   = PW'(gray2bin(ptr_t'(wgray_s)));
  assign avail    = wbin_s - rbin;
  // the slot named by the synchronized write pointer is never entered
  assign rd_empty = (rbin == wbin_s);
  assign rd_fire  = rd_en && !rd_empty;
  assign rbin_nxt = rbin + PW'(1);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        rbin  <= rbin_nxt;
        rgray <= PW'(bin2gray(ptr_t'(rbin_nxt)));
      end
    end
  end

  assert_no_underread_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    avail <= PW'(DEPTH));
  assert_valid_after_req_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |-> $past(rd_en));
  assert_gray_step_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/xdom_pkt_fifo.sv
`timescale 1ns/1ps
module xdom_pkt_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 3
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_fire, rd_fire;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;

  xfifo_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .wr_full(wr_full), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray)
  );

  xfifo_rd_ctl #(.AW(AW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .rd_empty(rd_empty), .rd_fire(rd_fire), .rd_valid(rd_valid),
    .raddr(raddr), .rgray(rgray)
  );

  xfifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  xfifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)      rd_data <= '0;
    else if (rd_fire) rd_data <= mem[raddr];
  end
endmodule

// File: tb/tb_xdom_pkt_fifo.sv
`timescale 1ns/1ps
module tb_xdom_pkt_fifo;
  localparam int DATA_W = 8;
  localparam int AW     = 3;
  localparam int DEPTH  = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, wrst_n = 1'b0, rrst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_full, rd_valid, rd_empty;
  logic [DATA_W-1:0] rd_data;

  int checks = 0, failures = 0, wcyc = 0, rcyc = 0;
  int wr_cnt = 0, rd_cnt = 0;
  bit done = 0;
  logic [DATA_W-1:0] exp_q [0:1023];
  logic [DATA_W-1:0] last_data = '0;

  always #4.0 wclk = ~wclk;   // 125 MHz producer clock
  always #4.3 rclk = ~rclk;   // slightly slower consumer clock

  xdom_pkt_fifo #(.DATA_W(DATA_W), .AW(AW)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pattern(input int i);
    return DATA_W'((i * 37 + 5) & 255);
  endfunction

  task automatic run_writer(input int target, input int mode);
    while (wr_cnt < target) begin
      @(negedge wclk);
      wcyc++;
      wr_en   = (mode == 0) ? 1'b1 : ((wcyc % 5) != 3);
      wr_data = pattern(wr_cnt);
      if (wr_en && !wr_full) begin
        exp_q[wr_cnt] = wr_data;
        wr_cnt++;
      end
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic run_reader(input int target, input int mode);
    bit pending = 0;
    int guard = 0;
    while ((rd_cnt < target || pending) && guard < 20000) begin
      @(negedge rclk);
      rcyc++; guard++;
      if (pending) begin
        check(rd_valid == 1'b1, "R5 valid after accepted read", int'(rd_valid), 1);
        check(rd_data == exp_q[rd_cnt], "R2/R8 order", int'(rd_data), int'(exp_q[rd_cnt]));
        last_data = rd_data;
        rd_cnt++;
      end else begin
        check(rd_valid == 1'b0, "R5 no valid without read", int'(rd_valid), 0);
        check(rd_data == last_data, "R5 data held", int'(rd_data), int'(last_data));
      end
      if (rd_cnt < target) begin
        case (mode)
          0:       rd_en = 1'b1;
          1:       rd_en = (rcyc % 7) != 0;
          default: rd_en = (rcyc % 3) == 0;
        endcase
      end else rd_en = 1'b0;
      pending = rd_en && !rd_empty;
    end
    check(guard < 20000, "R8 reader progress", guard, 0);
    rd_en = 1'b0;
  endtask

  always @(posedge wclk) begin
    if (!done && wcyc >= 0) begin
      if ($time > 1000000) begin
        done = 1;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", rd_cnt, wr_cnt);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(posedge wclk);
    #1;
    // R1: state while held in reset
    check(rd_empty == 1'b1, "R1 empty in reset", int'(rd_empty), 1);
    check(wr_full == 1'b0, "R1 full in reset", int'(wr_full), 0);
    check(rd_valid == 1'b0, "R1 valid in reset", int'(rd_valid), 0);
    wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (3) @(negedge rclk);
    check(rd_empty == 1'b1 && wr_full == 1'b0 && rd_valid == 1'b0,
          "R1 state after release", {rd_empty, wr_full, rd_valid}, 3'b100);

    // R4: reads on an empty FIFO do nothing
    for (int i = 0; i < 4; i++) begin
      @(negedge rclk);
      rd_en = 1'b1;
      check(rd_valid == 1'b0, "R4 empty read ignored", int'(rd_valid), 0);
    end
    @(negedge rclk); rd_en = 1'b0;
    check(rd_valid == 1'b0, "R4 empty read ignored", int'(rd_valid), 0);

    // R6: single write does not clear empty on its own edge
    @(negedge wclk);
    wr_en = 1'b1; wr_data = 8'hA5;
    exp_q[wr_cnt] = 8'hA5; wr_cnt++;
    @(posedge wclk); #0.5;
    check(rd_empty == 1'b1, "R6 empty held on write edge", int'(rd_empty), 1);
    @(negedge wclk); wr_en = 1'b0;
    repeat (4) @(negedge rclk);
    check(rd_empty == 1'b0, "R6 word visible after sync", int'(rd_empty), 0);
    run_reader(wr_cnt, 0);   // R5 via reader checks
    @(negedge rclk);
    check(rd_empty == 1'b1, "R4 empty after drain", int'(rd_empty), 1);

    // R3: fill to full, extra writes dropped
    for (int i = 0; i < DEPTH + 3; i++) begin
      @(negedge wclk);
      check(wr_full == (i >= DEPTH), "R3 full after DEPTH writes", int'(wr_full), int'(i >= DEPTH));
      wr_en = 1'b1; wr_data = DATA_W'(8'h40 + i);
      if (i < DEPTH) begin exp_q[wr_cnt] = wr_data; wr_cnt++; end
    end
    @(negedge wclk); wr_en = 1'b0;
    run_reader(wr_cnt, 0);   // R2/R3: exactly DEPTH words, in order
    for (int i = 0; i < 3; i++) begin
      @(negedge rclk);
      rd_en = 1'b1;
      check(rd_valid == 1'b0, "R3 dropped writes never read", int'(rd_valid), 0);
    end
    @(negedge rclk); rd_en = 1'b0;
    repeat (5) @(negedge wclk);
    check(wr_full == 1'b0, "R7 full clears after drain", int'(wr_full), 1'b0);

    // R8: streams with gappy producer / fast consumer, then slow consumer
    fork
      run_writer(wr_cnt + 150, 1);
      run_reader(wr_cnt + 150, 1);
    join
    fork
      run_writer(wr_cnt + 150, 0);
      run_reader(wr_cnt + 150, 2);
    join
    check(rd_cnt == wr_cnt, "R8 count in equals count out", rd_cnt, wr_cnt);
    repeat (4) @(negedge rclk);
    check(rd_empty == 1'b1, "R8 empty at end", int'(rd_empty), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule